// File: doc/BRIEF.md
# Speed-Routed Bused MII Multiplexer

This block sits between four transceiver ports and a repeater that serves them over two shared buses. Ports negotiated to 100 Mb/s are joined onto a nibble-wide bus (bus A) carrying receive data, receive valid, receive error, transmit data and transmit error. Ports negotiated to 10 Mb/s are joined onto a one-bit serial bus (bus B) with a single receive bit and a single transmit bit. Each port's speed comes in on a per-port speed input. That input holds the autonegotiation result, so no routing has to be set up by hand.

The repeater decides which port may use a bus by raising per-port enables. Two submodes change how those enables and the carrier and collision indications look. In the separate submode, every port has its own pair of receive enables, transmit enables, carrier indications and collision indications, one of each pair for each speed. In the smart submode, each port has one receive enable and one carrier indication for both speeds, and a single transmit enable and a single collision indication serve all ports. Every output is registered, so each result appears one clock after the inputs that cause it.

Top module: `bused_mii_router`

## Requirements
- R1: While reset is asserted (rstN low), every output is zero.
- R2: A port with portFast high whose bus A receive enable is asserted drives its receive nibble, valid and error onto busARxData, busARxDv and busARxEr one clock later.
- R3: A port with portFast low whose bus B receive enable is asserted drives its serial receive bit onto busBRxSer one clock later.
- R4: An enable for the speed a port is not running at is ignored. This applies to receive enables and to transmit enables.
- R5: When no port holds a receive grant on a bus, that bus's receive outputs are zero one clock later: data 0, valid 0 and error 0.
- R6: When several eligible ports request the same bus, the port with the lowest index wins.
- R7: Bus A transmit data and transmit error reach only those ports whose portFast is high and whose transmit enable is asserted. Every other port gets data 0 and error 0. phyTxEn is high exactly for the ports that are reached.
- R8: busBTxSer reaches only those ports whose portFast is low and whose transmit enable is asserted. Every other port gets phyTxSer 0.
- R9: In the separate submode (smartMode = 0), each port's carrier and collision indications appear on crsFast and colFast if portFast is 1, and on crsSlow and colSlow if portFast is 0.
- R10: In the smart submode (smartMode = 1), rxEnShared selects the receiver and txEnShared drives every port on its speed's bus. crsShared mirrors each port's carrier, and colShared is the OR of all port collisions. The per-speed enables are ignored and the per-speed indications are zero.
- R11: In the separate submode, rxEnShared and txEnShared are ignored, and crsShared and colShared are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| smartMode | input | 1 | 0 selects the separate submode, 1 selects the smart submode |
| portFast | input | 4 | Per-port negotiated speed, 1 = 100 Mb/s |
| phyRxData | input | 4x4 | Per-port receive nibble |
| phyRxDv | input | 4 | Per-port receive valid |
| phyRxEr | input | 4 | Per-port receive error |
| phyRxSer | input | 4 | Per-port 10 Mb/s serial receive bit |
| phyCrs | input | 4 | Per-port carrier activity |
| phyCol | input | 4 | Per-port collision activity |
| phyTxData | output | 4x4 | Per-port transmit nibble |
| phyTxEn | output | 4 | Per-port transmit enable toward the transceiver |
| phyTxEr | output | 4 | Per-port transmit error |
| phyTxSer | output | 4 | Per-port 10 Mb/s serial transmit bit |
| busARxData | output | 4 | Bus A receive nibble |
| busARxDv | output | 1 | Bus A receive valid |
| busARxEr | output | 1 | Bus A receive error |
| busATxData | input | 4 | Bus A transmit nibble |
| busATxEr | input | 1 | Bus A transmit error |
| busBRxSer | output | 1 | Bus B serial receive bit |
| busBTxSer | input | 1 | Bus B serial transmit bit |
| rxEnFast | input | 4 | Separate submode: per-port bus A receive enable |
| rxEnSlow | input | 4 | Separate submode: per-port bus B receive enable |
| txEnFast | input | 4 | Separate submode: per-port bus A transmit enable |
| txEnSlow | input | 4 | Separate submode: per-port bus B transmit enable |
| crsFast | output | 4 | Separate submode: carrier of 100 Mb/s ports |
| crsSlow | output | 4 | Separate submode: carrier of 10 Mb/s ports |
| colFast | output | 4 | Separate submode: collision of 100 Mb/s ports |
| colSlow | output | 4 | Separate submode: collision of 10 Mb/s ports |
| rxEnShared | input | 4 | Smart submode: per-port receive enable for both speeds |
| txEnShared | input | 1 | Smart submode: common transmit enable |
| crsShared | output | 4 | Smart submode: per-port carrier |
| colShared | output | 1 | Smart submode: common collision |

## Verification
The hardest cases to reach from the ports are those where requests compete or are misdirected. One is several ports asking for the same bus at once. Another is an enable raised for a port whose speed points it at the other bus. A third is per-speed enables held active while the block is in the smart submode, or shared enables held active in the separate submode. The table of vectors combines speed masks with receive-enable masks so that each of these situations comes up. Each port carries a distinct receive nibble, so the value seen on bus A identifies which port won. Directed steps then drive the transmit buses with enables deliberately raised on ports of the wrong speed.

// File: rtl/bmux_pkg.sv
package bmux_pkg;

  typedef enum logic {
    SUB_SEPARATE = 1'b0,
    SUB_SMART    = 1'b1
  } subMode_e;

  // Per-port strobes handed from the control to the datapath.
  typedef struct packed {
    logic rxGrantFast;
    logic rxGrantSlow;
    logic txGateFast;
    logic txGateSlow;
  } portStrobe_t;

endpackage

// File: rtl/bmux_ctrl.sv
module bmux_ctrl
  import bmux_pkg::*;
#(
  parameter int NumPorts = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       smartMode,
  input  logic [NumPorts-1:0]        portFast,
  input  logic [NumPorts-1:0]        rxEnFast,
  input  logic [NumPorts-1:0]        rxEnSlow,
  input  logic [NumPorts-1:0]        txEnFast,
  input  logic [NumPorts-1:0]        txEnSlow,
  input  logic [NumPorts-1:0]        rxEnShared,
  input  logic                       txEnShared,
  output portStrobe_t [NumPorts-1:0] strobes
);

  subMode_e mode;
  logic [NumPorts-1:0] reqFast, reqSlow, grantFast, grantSlow;
  logic [NumPorts-1:0] gateFast, gateSlow;
  logic [NumPorts:0]   takenFast, takenSlow;

  assign mode = subMode_e'(smartMode);

  always_comb begin
    for (int i = 0; i < NumPorts; i++) begin
      if (mode == SUB_SMART) begin
        reqFast[i]  = portFast[i]  & rxEnShared[i];
        reqSlow[i]  = ~portFast[i] & rxEnShared[i];
        gateFast[i] = portFast[i]  & txEnShared;
        gateSlow[i] = ~portFast[i] & txEnShared;
      end else begin
        reqFast[i]  = portFast[i]  & rxEnFast[i];
        reqSlow[i]  = ~portFast[i] & rxEnSlow[i];
        gateFast[i] = portFast[i]  & txEnFast[i];
        gateSlow[i] = ~portFast[i] & txEnSlow[i];
      end
    end
  end

  // Lowest-index priority chain, one per bus.
  assign takenFast[0] = 1'b0;
  assign takenSlow[0] = 1'b0;
  for (genvar g = 0; g < NumPorts; g++) begin : gPrio
    assign takenFast[g+1] = takenFast[g] | reqFast[g];
    assign takenSlow[g+1] = takenSlow[g] | reqSlow[g];
    assign grantFast[g]   = reqFast[g] & ~takenFast[g];
    assign grantSlow[g]   = reqSlow[g] & ~takenSlow[g];
    assign strobes[g] = '{rxGrantFast: grantFast[g], rxGrantSlow: grantSlow[g],
                          txGateFast: gateFast[g], txGateSlow: gateSlow[g]};
  end

  assert_fast_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantFast));
  assert_slow_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantSlow));
  assert_fast_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqFast[0] |-> grantFast[0]));

endmodule

// File: rtl/bmux_datapath.sv
module bmux_datapath
  import bmux_pkg::*;
#(
  parameter int NumPorts = 4,
  parameter int NibbleW  = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              smartMode,
  input  logic [NumPorts-1:0]               portFast,
  input  portStrobe_t [NumPorts-1:0]        strobes,
  input  logic [NumPorts-1:0][NibbleW-1:0]  phyRxData,
  input  logic [NumPorts-1:0]               phyRxDv,
  input  logic [NumPorts-1:0]               phyRxEr,
  input  logic [NumPorts-1:0]               phyRxSer,
  input  logic [NumPorts-1:0]               phyCrs,
  input  logic [NumPorts-1:0]               phyCol,
  input  logic [NibbleW-1:0]                busATxData,
  input  logic                              busATxEr,
  input  logic                              busBTxSer,
  output logic [NumPorts-1:0][NibbleW-1:0]  phyTxData,
  output logic [NumPorts-1:0]               phyTxEn,
  output logic [NumPorts-1:0]               phyTxEr,
  output logic [NumPorts-1:0]               phyTxSer,
  output logic [NibbleW-1:0]                busARxData,
  output logic                              busARxDv,
  output logic                              busARxEr,
  output logic                              busBRxSer,
  output logic [NumPorts-1:0]               crsFast,
  output logic [NumPorts-1:0]               crsSlow,
  output logic [NumPorts-1:0]               colFast,
  output logic [NumPorts-1:0]               colSlow,
  output logic [NumPorts-1:0]               crsShared,
  output logic                              colShared
);

  logic [NibbleW-1:0]               nxtAData;
  logic                             nxtADv, nxtAEr, nxtBSer;
  logic [NumPorts-1:0][NibbleW-1:0] nxtTxData;
  logic [NumPorts-1:0]              nxtTxEn, nxtTxEr, nxtTxSer;
  logic [NumPorts-1:0]              nxtCrsF, nxtCrsS, nxtColF, nxtColS, nxtCrsSh;
  logic                             nxtColSh;
  logic [NumPorts-1:0]              anyGrantFast, anyGrantSlow;

  always_comb begin
    nxtAData = '0;
    nxtADv   = 1'b0;
    nxtAEr   = 1'b0;
    nxtBSer  = 1'b0;
    for (int i = 0; i < NumPorts; i++) begin
      anyGrantFast[i] = strobes[i].rxGrantFast;
      anyGrantSlow[i] = strobes[i].rxGrantSlow;
      if (strobes[i].rxGrantFast) begin
        nxtAData = nxtAData | phyRxData[i];
        nxtADv   = nxtADv | phyRxDv[i];
        nxtAEr   = nxtAEr | phyRxEr[i];
      end
      if (strobes[i].rxGrantSlow) nxtBSer = nxtBSer | phyRxSer[i];
      nxtTxData[i] = strobes[i].txGateFast ? busATxData : '0;
      nxtTxEr[i]   = strobes[i].txGateFast & busATxEr;
      nxtTxSer[i]  = strobes[i].txGateSlow & busBTxSer;
      nxtTxEn[i]   = strobes[i].txGateFast | strobes[i].txGateSlow;
      nxtCrsF[i]   = ~smartMode & portFast[i]  & phyCrs[i];
      nxtCrsS[i]   = ~smartMode & ~portFast[i] & phyCrs[i];
      nxtColF[i]   = ~smartMode & portFast[i]  & phyCol[i];
      nxtColS[i]   = ~smartMode & ~portFast[i] & phyCol[i];
      nxtCrsSh[i]  = smartMode & phyCrs[i];
    end
    nxtColSh = smartMode & (|phyCol);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busARxData <= '0;
      busARxDv   <= 1'b0;
      busARxEr   <= 1'b0;
      busBRxSer  <= 1'b0;
      phyTxData  <= '0;
      phyTxEn    <= '0;
      phyTxEr    <= '0;
      phyTxSer   <= '0;
      crsFast    <= '0;
      crsSlow    <= '0;
      colFast    <= '0;
      colSlow    <= '0;
      crsShared  <= '0;
      colShared  <= 1'b0;
    end else begin
      busARxData <= nxtAData;
      busARxDv   <= nxtADv;
      busARxEr   <= nxtAEr;
      busBRxSer  <= nxtBSer;
      phyTxData  <= nxtTxData;
      phyTxEn    <= nxtTxEn;
      phyTxEr    <= nxtTxEr;
      phyTxSer   <= nxtTxSer;
      crsFast    <= nxtCrsF;
      crsSlow    <= nxtCrsS;
      colFast    <= nxtColF;
      colSlow    <= nxtColS;
      crsShared  <= nxtCrsSh;
      colShared  <= nxtColSh;
    end
  end

  assert_idle_busA_R5: assert property (@(posedge clk) disable iff (!rstN)
    (anyGrantFast == '0) |=> (busARxData == '0 && !busARxDv && !busARxEr));
  assert_idle_busB_R5: assert property (@(posedge clk) disable iff (!rstN)
    (anyGrantSlow == '0) |=> !busBRxSer);
  assert_smart_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    smartMode |=> (crsFast == '0 && crsSlow == '0 && colFast == '0 && colSlow == '0));
  assert_sep_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !smartMode |=> (crsShared == '0 && !colShared));

  for (genvar g = 0; g < NumPorts; g++) begin : gPortChk
    assert_tx_isolate_R7: assert property (@(posedge clk) disable iff (!rstN)
      !strobes[g].txGateFast |=> (phyTxData[g] == '0 && !phyTxEr[g]));
    assert_ser_isolate_R8: assert property (@(posedge clk) disable iff (!rstN)
      !strobes[g].txGateSlow |=> !phyTxSer[g]);
    assert_speed_split_R9: assert property (@(posedge clk) disable iff (!rstN)
      !(crsFast[g] && crsSlow[g]));
  end

endmodule

// File: rtl/bused_mii_router.sv
module bused_mii_router
  import bmux_pkg::*;
#(
  parameter int NumPorts = 4,
  parameter int NibbleW  = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             smartMode,
  input  logic [NumPorts-1:0]              portFast,
  input  logic [NumPorts-1:0][NibbleW-1:0] phyRxData,
  input  logic [NumPorts-1:0]              phyRxDv,
  input  logic [NumPorts-1:0]              phyRxEr,
  input  logic [NumPorts-1:0]              phyRxSer,
  input  logic [NumPorts-1:0]              phyCrs,
  input  logic [NumPorts-1:0]              phyCol,
  output logic [NumPorts-1:0][NibbleW-1:0] phyTxData,
  output logic [NumPorts-1:0]              phyTxEn,
  output logic [NumPorts-1:0]              phyTxEr,
  output logic [NumPorts-1:0]              phyTxSer,
  output logic [NibbleW-1:0]               busARxData,
  output logic                             busARxDv,
  output logic                             busARxEr,
  input  logic [NibbleW-1:0]               busATxData,
  input  logic                             busATxEr,
  output logic                             busBRxSer,
  input  logic                             busBTxSer,
  input  logic [NumPorts-1:0]              rxEnFast,
  input  logic [NumPorts-1:0]              rxEnSlow,
  input  logic [NumPorts-1:0]              txEnFast,
  input  logic [NumPorts-1:0]              txEnSlow,
  output logic [NumPorts-1:0]              crsFast,
  output logic [NumPorts-1:0]              crsSlow,
  output logic [NumPorts-1:0]              colFast,
  output logic [NumPorts-1:0]              colSlow,
  input  logic [NumPorts-1:0]              rxEnShared,
  input  logic                             txEnShared,
  output logic [NumPorts-1:0]              crsShared,
  output logic                             colShared
);

  portStrobe_t [NumPorts-1:0] strobes;

  bmux_ctrl #(.NumPorts(NumPorts)) uCtrl (
    .clk(clk), .rstN(rstN), .smartMode(smartMode), .portFast(portFast),
    .rxEnFast(rxEnFast), .rxEnSlow(rxEnSlow), .txEnFast(txEnFast),
    .txEnSlow(txEnSlow), .rxEnShared(rxEnShared), .txEnShared(txEnShared),
    .strobes(strobes)
  );

  bmux_datapath #(.NumPorts(NumPorts), .NibbleW(NibbleW)) uData (
    .clk(clk), .rstN(rstN), .smartMode(smartMode), .portFast(portFast),
    .strobes(strobes), .phyRxData(phyRxData), .phyRxDv(phyRxDv),
    .phyRxEr(phyRxEr), .phyRxSer(phyRxSer), .phyCrs(phyCrs), .phyCol(phyCol),
    .busATxData(busATxData), .busATxEr(busATxEr), .busBTxSer(busBTxSer),
    .phyTxData(phyTxData), .phyTxEn(phyTxEn), .phyTxEr(phyTxEr),
    .phyTxSer(phyTxSer), .busARxData(busARxData), .busARxDv(busARxDv),
    .busARxEr(busARxEr), .busBRxSer(busBRxSer), .crsFast(crsFast),
    .crsSlow(crsSlow), .colFast(colFast), .colSlow(colSlow),
    .crsShared(crsShared), .colShared(colShared)
  );

endmodule

// File: tb/tb_bused_mii_router.sv
`timescale 1ns/100ps
module tb_bused_mii_router;

  localparam int NP = 4;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic smartMode;
  logic [NP-1:0] portFast, phyRxDv, phyRxEr, phyRxSer, phyCrs, phyCol;
  logic [NP-1:0][NW-1:0] phyRxData, phyTxData;
  logic [NP-1:0] phyTxEn, phyTxEr, phyTxSer;
  logic [NW-1:0] busARxData, busATxData;
  logic busARxDv, busARxEr, busATxEr, busBRxSer, busBTxSer;
  logic [NP-1:0] rxEnFast, rxEnSlow, txEnFast, txEnSlow, rxEnShared;
  logic [NP-1:0] crsFast, crsSlow, colFast, colSlow, crsShared;
  logic txEnShared, colShared;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bused_mii_router dut (.*);

  typedef struct packed {
    logic       smart;
    logic [3:0] fast;
    logic [3:0] rxF;
    logic [3:0] rxS;
    logic [3:0] rxSh;
    logic [2:0] expA;   // winning port on bus A, 4 = none
    logic [2:0] expB;   // winning port on bus B, 4 = none
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'b0011, 4'b0001, 4'b0100, 4'b0000, 3'd0, 3'd2},  // R2 R3
    '{1'b0, 4'b0011, 4'b0010, 4'b1100, 4'b0000, 3'd1, 3'd2},  // R6
    '{1'b0, 4'b0011, 4'b1100, 4'b0011, 4'b0000, 3'd4, 3'd4},  // R4
    '{1'b0, 4'b1111, 4'b1110, 4'b0000, 4'b0000, 3'd1, 3'd4},  // R6 R5
    '{1'b0, 4'b0000, 4'b0000, 4'b1010, 4'b0000, 3'd4, 3'd1},  // R3
    '{1'b1, 4'b0101, 4'b1111, 4'b1111, 4'b0000, 3'd4, 3'd4},  // R10
    '{1'b1, 4'b0101, 4'b0000, 4'b0000, 4'b0110, 3'd2, 3'd1},  // R10
    '{1'b1, 4'b1000, 4'b0000, 4'b0000, 4'b1001, 3'd3, 3'd0},  // R10 R6
    '{1'b0, 4'b0101, 4'b0000, 4'b0000, 4'b1111, 3'd4, 3'd4},  // R11
    '{1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd4, 3'd4}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    smartMode = 1'b0; portFast = '0; rxEnFast = '0; rxEnSlow = '0;
    txEnFast = '0; txEnSlow = '0; rxEnShared = '0; txEnShared = 1'b0;
    busATxData = '0; busATxEr = 1'b0; busBTxSer = 1'b0;
    phyCrs = '0; phyCol = '0;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // per-port receive sources: nibble 9+i, valid high, error on port 2 only
    for (int i = 0; i < NP; i++) phyRxData[i] = 4'(9 + i);
    phyRxDv  = 4'b1111;
    phyRxEr  = 4'b0100;
    phyRxSer = 4'b0110;
    idleInputs();
    // R1: busy inputs while in reset must not reach outputs
    smartMode = 1'b1; portFast = 4'b0011; rxEnShared = 4'b1111; txEnShared = 1'b1;
    busATxData = 4'hF; busATxEr = 1'b1; busBTxSer = 1'b1; phyCrs = '1; phyCol = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busA", {busARxData, busARxDv, busARxEr, busBRxSer}, '0);
    chk("R1 phyTx", {phyTxData, phyTxEn, phyTxEr, phyTxSer}, '0);
    chk("R1 status", {crsFast, crsSlow, colFast, colSlow, crsShared, colShared}, '0);
    @(negedge clk);
    idleInputs();
    rstN = 1'b1;

    // Table walk: receive routing
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      smartMode = VECS[v].smart; portFast = VECS[v].fast;
      rxEnFast = VECS[v].rxF; rxEnSlow = VECS[v].rxS; rxEnShared = VECS[v].rxSh;
      settle();
      if (VECS[v].expA == 3'd4)
        chk($sformatf("R5 R4 R11 busA idle vec%0d", v), {busARxData, busARxDv, busARxEr}, '0);
      else
        chk($sformatf("R2 R6 R10 busA vec%0d", v), {busARxData, busARxDv, busARxEr},
            {4'(9 + VECS[v].expA), 1'b1, (VECS[v].expA == 3'd2)});
      if (VECS[v].expB == 3'd4)
        chk($sformatf("R5 R4 busB idle vec%0d", v), 32'(busBRxSer), 32'd0);
      else
        chk($sformatf("R3 R6 busB vec%0d", v), 32'(busBRxSer), 32'(phyRxSer[VECS[v].expB[1:0]]));
    end

    // R7 R8 R4: separate submode transmit, wrong-speed enables raised
    @(negedge clk);
    idleInputs();
    portFast = 4'b0011; txEnFast = 4'b1010; txEnSlow = 4'b1001;
    busATxData = 4'hA; busATxEr = 1'b1; busBTxSer = 1'b1;
    settle();
    chk("R7 phyTxData", phyTxData, {4'h0, 4'h0, 4'hA, 4'h0});
    chk("R7 phyTxEr", phyTxEr, 4'b0010);
    chk("R8 phyTxSer", phyTxSer, 4'b1000);
    chk("R7 R8 phyTxEn", phyTxEn, 4'b1010);
    // R11: shared transmit enable ignored in separate submode
    @(negedge clk);
    txEnFast = '0; txEnSlow = '0; txEnShared = 1'b1;
    settle();
    chk("R11 phyTxEn", phyTxEn, 4'b0000);

    // R10: smart submode transmit, per-speed enables ignored
    @(negedge clk);
    smartMode = 1'b1; txEnShared = 1'b1; txEnFast = 4'b1111; txEnSlow = 4'b1111;
    settle();
    chk("R10 phyTxEn", phyTxEn, 4'b1111);
    chk("R10 phyTxData", phyTxData, {4'h0, 4'h0, 4'hA, 4'hA});
    chk("R10 phyTxSer", phyTxSer, 4'b1100);
    @(negedge clk);
    txEnShared = 1'b0;
    settle();
    chk("R10 R4 phyTxEn off", phyTxEn, 4'b0000);

    // R9: separate submode carrier and collision split by speed
    @(negedge clk);
    idleInputs();
    portFast = 4'b0011; phyCrs = 4'b0110; phyCol = 4'b1001;
    settle();
    chk("R9 crsFast", crsFast, 4'b0010);
    chk("R9 crsSlow", crsSlow, 4'b0100);
    chk("R9 colFast", colFast, 4'b0001);
    chk("R9 colSlow", colSlow, 4'b1000);
    chk("R11 shared quiet", {crsShared, colShared}, '0);

    // R10: smart submode carrier and collision
    @(negedge clk);
    smartMode = 1'b1;
    settle();
    chk("R10 crsShared", crsShared, 4'b0110);
    chk("R10 colShared", 32'(colShared), 32'd1);
    chk("R10 per-speed quiet", {crsFast, crsSlow, colFast, colSlow}, '0);
    @(negedge clk);
    phyCol = '0;
    settle();
    chk("R10 colShared low", 32'(colShared), 32'd0);

    // R1: reset asserted again mid-run clears outputs
    @(negedge clk);
    phyCrs = 4'b1111;
    rstN = 1'b0;
    #1;
    chk("R1 async clear", {crsShared, phyTxEn}, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule